// File: doc/BRIEF.md
# Fractional Baud Clock Generator

This block turns a fast reference clock into a one-cycle enable at sixteen times the chosen serial baud rate. A serial receiver or transmitter running on the same reference clock uses the enable to step its oversampling counters. The rate comes from a short table of divisors. Two of the divisors are not whole numbers: 16/3 and 32/3. Those two are built by mixing interval lengths in a fixed three-step cycle, so the average spacing is exact and no single interval is off by more than one reference cycle. The lowest table entry sets the tick to every reference cycle. That entry is for a reference that already runs at the 16x rate.

The block also drives a clock-output pin. That pin carries either the reference clock itself or a 16x baud clock. The baud clock is a square-ish wave that is high during the first half of each tick interval. The rate and the clock-out source come from one rate word, which is loaded with a write strobe. Each load restarts the divider from a clean interval.

Top module: `baud_tick_gen`

## Requirements
- R1: After reset the rate code is 0 and the clock-out select is 0. In this state `tick16` is high in every reference cycle and `clk_out` follows `ref_clk`.
- R2: The rate word is loaded at a rising `ref_clk` edge while `rate_wr` is high. Bits [2:0] hold the rate code and bit 7 holds the clock-out select. Bits [6:3] have no effect.
- R3: Codes 1, 2, 4, 6 and 7 give tick intervals of 2, 4, 8, 16 and 32 reference cycles.
- R4: Code 3 gives a divisor of 16/3. After a load, the intervals repeat in the order 5, 5, 6.
- R5: Code 5 gives a divisor of 32/3. After a load, the intervals repeat in the order 11, 11, 10.
- R6: A load restarts the divider. The first tick after the load comes exactly one first-interval length after the loading edge, and no tick appears before it, even if the old count was about to expire.
- R7: For every code other than 0, `tick16` is high for exactly one reference cycle per interval. That cycle is the last cycle of the interval.
- R8: Code 0 is the pass-through setting: `tick16` is high in every reference cycle.
- R9: When the select is 1 and the code is not 0, `clk_out` is high in the first ceil(L/2) cycles of each interval of length L and low in the rest. When the select is 1 and the code is 0, `clk_out` follows `ref_clk`.
- R10: When the select is 0, `clk_out` follows `ref_clk` for every code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock. Every register in the block runs on this clock. |
| rst | input | 1 | Asynchronous reset, active high |
| rate_wr | input | 1 | Write strobe for the rate word |
| rate_data | input | 8 | Rate word: [2:0] rate code, [7] clock-out select |
| tick16 | output | 1 | One-cycle enable at sixteen times the baud rate |
| clk_out | output | 1 | Reference clock or 16x baud clock, chosen by the select bit |

## Verification
A wrong phase index or a wrong reload value shows up as a shifted `tick16` within one interval of a load, at most 32 reference cycles. A wrong phase sequence in the fractional codes shows up as a 5/6 or 11/10 swap within three intervals. A count that is not reloaded on a write shows up as a runt tick in the cycle the old count would have expired. The bench forces this case by writing just before expiry. A stuck baud-clock register changes the duty pattern on `clk_out` within the first interval after a load with the select set.

// File: rtl/baud_pkg.sv
package baud_pkg;

    parameter int CNT_W   = 6;
    parameter int PHASE_N = 3;

    typedef enum logic [2:0] {
        RATE_PASS  = 3'd0,
        RATE_DIV2  = 3'd1,
        RATE_DIV4  = 3'd2,
        RATE_DIV16_3 = 3'd3,
        RATE_DIV8  = 3'd4,
        RATE_DIV32_3 = 3'd5,
        RATE_DIV16 = 3'd6,
        RATE_DIV32 = 3'd7
    } rate_code_e;

    // interval length in reference cycles for a code and a phase of the 3-step cycle
    function automatic logic [CNT_W-1:0] interval_len(input rate_code_e code,
                                                      input logic [1:0] phase);
        logic [CNT_W-1:0] len;
        case (code)
            RATE_PASS:    len = CNT_W'(1);
            RATE_DIV2:    len = CNT_W'(2);
            RATE_DIV4:    len = CNT_W'(4);
            RATE_DIV16_3: len = (phase == 2'd2) ? CNT_W'(6) : CNT_W'(5);
            RATE_DIV8:    len = CNT_W'(8);
            RATE_DIV32_3: len = (phase == 2'd2) ? CNT_W'(10) : CNT_W'(11);
            RATE_DIV16:   len = CNT_W'(16);
            default:      len = CNT_W'(32);
        endcase
        return len;
    endfunction

endpackage

// File: rtl/baud_rate_reg.sv
module baud_rate_reg
    import baud_pkg::*;
#(
    parameter int WORD_W  = 8,
    parameter int SEL_BIT = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_i,
    input  logic [WORD_W-1:0] data_i,
    output rate_code_e        code_o,
    output logic              sel_o
);

    typedef struct packed {
        rate_code_e code;
        logic       sel;
    } reg_state_t;

    reg_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_i) begin
            st_d.code = rate_code_e'(data_i[2:0]);
            st_d.sel  = data_i[SEL_BIT];
        end
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            st_q <= '{code: RATE_PASS, sel: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign code_o = st_q.code;
    assign sel_o  = st_q.sel;

    AST_RATE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !wr_i |=> ($stable(code_o) && $stable(sel_o))); // R2

endmodule

// File: rtl/baud_frac_div.sv
module baud_frac_div
    import baud_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       load_i,
    input  rate_code_e load_code_i,
    input  rate_code_e code_i,
    output logic       tick_o,
    output logic       bclk_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [1:0]       phase;
        logic             bclk;
    } div_state_t;

    div_state_t       st_d, st_q;
    rate_code_e       use_code;
    logic [CNT_W-1:0] first_len;
    logic [CNT_W-1:0] next_len;
    logic [1:0]       phase_nx;

    always_comb begin
        st_d      = st_q;
        first_len = interval_len(load_code_i, 2'd0);
        phase_nx  = (st_q.phase == 2'(PHASE_N - 1)) ? 2'd0 : st_q.phase + 2'd1;
        use_code  = code_i;
        if (load_i) begin
            use_code   = load_code_i;
            st_d.phase = 2'd0;
            st_d.cnt   = first_len - CNT_W'(1);
        end else if (st_q.cnt == '0) begin
            st_d.phase = phase_nx;
            st_d.cnt   = interval_len(code_i, phase_nx) - CNT_W'(1);
        end else begin
            st_d.cnt   = st_q.cnt - CNT_W'(1);
        end
        next_len  = interval_len(use_code, st_d.phase);
        st_d.bclk = (st_d.cnt >= (next_len >> 1));
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            st_q <= '{cnt: '0, phase: 2'd0, bclk: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

    assign tick_o = (st_q.cnt == '0);
    assign bclk_o = st_q.bclk;

    AST_NO_RUNT: assert property (@(posedge clk) disable iff (rst)
        (load_i && first_len > CNT_W'(1)) |=> !tick_o); // R6
    AST_TICK_ONE_WIDE: assert property (@(posedge clk) disable iff (rst)
        (tick_o && !load_i && code_i != RATE_PASS) |=> !tick_o); // R7
    AST_PHASE_RANGE: assert property (@(posedge clk) disable iff (rst)
        st_q.phase < 2'(PHASE_N)); // R4
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        st_q.cnt < CNT_W'(32)); // R3

endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
    import baud_pkg::*;
#(
    parameter int WORD_W  = 8,
    parameter int SEL_BIT = 7
) (
    input  logic              ref_clk,
    input  logic              rst,
    input  logic              rate_wr,
    input  logic [WORD_W-1:0] rate_data,
    output logic              tick16,
    output logic              clk_out
);

    rate_code_e code;
    logic       sel;
    logic       bclk;

    baud_rate_reg #(.WORD_W(WORD_W), .SEL_BIT(SEL_BIT)) u_rate (
        .clk    (ref_clk),
        .rst    (rst),
        .wr_i   (rate_wr),
        .data_i (rate_data),
        .code_o (code),
        .sel_o  (sel)
    );

    baud_frac_div u_div (
        .clk         (ref_clk),
        .rst         (rst),
        .load_i      (rate_wr),
        .load_code_i (rate_code_e'(rate_data[2:0])),
        .code_i      (code),
        .tick_o      (tick16),
        .bclk_o      (bclk)
    );

    assign clk_out = (sel && code != RATE_PASS) ? bclk : ref_clk;

    AST_PASS_EVERY: assert property (@(posedge ref_clk) disable iff (rst)
        (code == RATE_PASS) |-> tick16); // R8

endmodule

// File: tb/baud_tick_gen_tb.sv
module baud_tick_gen_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr  = 1'b0;
    logic [7:0] data = 8'h00;
    logic       tick, cko;
    int         checks = 0;
    int         fails  = 0;

    always #4 clk = ~clk;

    baud_tick_gen dut_i (
        .ref_clk(clk), .rst(rst), .rate_wr(wr), .rate_data(data),
        .tick16(tick), .clk_out(cko)
    );

    typedef struct packed {
        logic [7:0] rate;
        logic [7:0] l0;
        logic [7:0] l1;
        logic [7:0] l2;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{8'h00, 8'd1,  8'd1,  8'd1},
        '{8'h01, 8'd2,  8'd2,  8'd2},
        '{8'h02, 8'd4,  8'd4,  8'd4},
        '{8'h03, 8'd5,  8'd5,  8'd6},
        '{8'h04, 8'd8,  8'd8,  8'd8},
        '{8'h05, 8'd11, 8'd11, 8'd10},
        '{8'h06, 8'd16, 8'd16, 8'd16},
        '{8'h07, 8'd32, 8'd32, 8'd32},
        '{8'h83, 8'd5,  8'd5,  8'd6},
        '{8'h85, 8'd11, 8'd11, 8'd10},
        '{8'h81, 8'd2,  8'd2,  8'd2},
        '{8'h86, 8'd16, 8'd16, 8'd16},
        '{8'h7B, 8'd5,  8'd5,  8'd6}
    };

    function automatic string tick_tag(input logic [7:0] r);
        if (r[6:3] != 4'd0) return "R2";
        case (r[2:0])
            3'd0: return "R8";
            3'd3: return "R4";
            3'd5: return "R5";
            default: return "R3";
        endcase
    endfunction

    task automatic check(input string req, input logic ok, input int act, input int exp, input string what);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // write at the edge between two negedges; returns at negedge after the load (sample k=0 follows)
    task automatic load(input logic [7:0] v);
        @(negedge clk);
        wr = 1'b1; data = v;
        @(negedge clk);
        wr = 1'b0; data = 8'h00;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state: tick every cycle, clk_out follows reference
        repeat (2) @(negedge clk);
        #1 check("R1", tick === 1'b1, tick, 1, "tick after reset");
        check("R1", cko === 1'b0, cko, 0, "clk_out low phase");
        @(posedge clk); #1 check("R1", cko === 1'b1, cko, 1, "clk_out high phase");

        // table walk
        for (int v = 0; v < NV; v++) begin
            int lens [3];
            int total, k_int, pos, ph, tick_bad, clk_bad, fk, fa, fe, ck_fk;
            logic exp_t, exp_c;
            lens[0] = VECS[v].l0; lens[1] = VECS[v].l1; lens[2] = VECS[v].l2;
            total = 3 * (lens[0] + lens[1] + lens[2]);
            tick_bad = 0; clk_bad = 0; fk = -1; ck_fk = -1; fa = 0; fe = 0;
            load(VECS[v].rate);
            pos = 0; ph = 0;
            for (int k = 0; k < total; k++) begin
                #1;
                exp_t = (pos == lens[ph] - 1);
                if (VECS[v].rate[7] && VECS[v].rate[2:0] != 3'd0)
                    exp_c = (pos < (lens[ph] + 1) / 2);
                else
                    exp_c = 1'b0;
                if (tick !== exp_t) begin
                    tick_bad++;
                    if (fk < 0) begin fk = k; fa = tick; fe = exp_t; end
                end
                if (cko !== exp_c && ck_fk < 0) ck_fk = k;
                if (cko !== exp_c) clk_bad++;
                if (pos == lens[ph] - 1) begin pos = 0; ph = (ph + 1) % 3; end
                else pos++;
                @(negedge clk);
            end
            k_int = fk;
            check(tick_tag(VECS[v].rate), tick_bad == 0, fa, fe,
                  $sformatf("tick rate %02h first bad sample %0d", VECS[v].rate, k_int));
            check(VECS[v].rate[7] ? "R9" : "R10", clk_bad == 0, clk_bad, 0,
                  $sformatf("clk_out mismatches rate %02h from sample %0d", VECS[v].rate, ck_fk));
        end

        // R7: single-cycle tick width, code 4
        begin
            int wide;
            wide = 0;
            load(8'h04);
            for (int k = 0; k < 40; k++) begin
                #1 if (tick && k > 0) wide += 0;
                @(negedge clk);
                #1 if (tick) begin @(negedge clk); #1 if (tick) wide++; end
            end
            check("R7", wide == 0, wide, 0, "consecutive tick cycles");
        end

        // R6: reload just before expiry, no runt tick
        begin
            int seen, first;
            load(8'h06);
            for (int k = 0; k < 14; k++) @(negedge clk);
            #1;
            // sample k=14 taken; next edge would expire; reload there
            wr = 1'b1; data = 8'h06;
            @(negedge clk);
            wr = 1'b0; data = 8'h00;
            seen = 0; first = -1;
            for (int k = 0; k < 16; k++) begin
                #1 if (tick) begin seen++; if (first < 0) first = k; end
                @(negedge clk);
            end
            check("R6", seen == 1 && first == 15, first, 15, "first tick after reload");
        end

        // R9 pass-through with select set: clk_out follows reference
        load(8'h80);
        #1 check("R9", cko === 1'b0, cko, 0, "pass sel clk_out low phase");
        @(posedge clk); #1 check("R9", cko === 1'b1, cko, 1, "pass sel clk_out high phase");

        // R10: select clear with divided code
        load(8'h06);
        @(posedge clk); #1 check("R10", cko === 1'b1, cko, 1, "ref on clk_out high phase");
        @(negedge clk); #1 check("R10", cko === 1'b0, cko, 0, "ref on clk_out low phase");

        // R1: reset mid-run restores pass-through
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        @(negedge clk);
        #1 check("R1", tick === 1'b1, tick, 1, "tick after second reset");

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule